// File: doc/BRIEF.md
# Serial Divider Programming Port

This block lets a host program three divider settings over a three-wire serial link: a data line, a shift clock and a load enable. Bits enter a 32-bit shift register on each rising edge of the shift clock. While the load enable is high, the register's fields are copied into three held outputs. These are a 14-bit reference divide value, a 10-bit main divide value and a 7-bit swallow divide value. The last bit shifted in is a control flag. When the flag is 1, the reference value is taken. When it is 0, the reference value keeps its old setting. The main and swallow values are taken on every load. The top bit of the shift register is driven out unchanged, so that further devices can be chained behind this one.

All three serial pins are asynchronous to the block's system clock. Each passes through its own synchronizer. The shift clock is then edge-detected in the system domain. The serial link has no stall mechanism, so there is no back-pressure: the host paces the link itself. It must hold each pin level for at least four system clocks. The divide outputs are plain levels, not a stream.

Top module: `synth_prog_port`

## Requirements
- R1: Each rising edge of the synchronized shift clock, seen while load enable is low, moves every register bit up one position and places the data pin's value in bit 0. No other cycle changes the register.
- R2: After 32 shifts, bits [31:18] hold the reference value, [17:8] the main value, [7:1] the swallow value and bit 0 the control flag. Each field is sent most significant bit first, reference first and control flag last.
- R3: While load enable is high and the control flag (bit 0) is 1, the reference output takes bits [31:18].
- R4: While load enable is high and the control flag is 0, the reference output keeps its previous value.
- R5: While load enable is high, the main output takes bits [17:8] and the swallow output takes bits [7:1], whatever the control flag.
- R6: While load enable is low, none of the three divide outputs changes, even while new bits are being shifted in.
- R7: The serial output equals register bit 31 at all times, whether load enable is high or low.
- R8: Shift clock rising edges that occur while load enable is high leave the register, and so the serial output, unchanged.
- R9: After reset, the reference output is 3, the main output is 16, the swallow output is 0 and the serial output is 0.
- R10: A pin change reaches the outputs on the third rising system clock edge after it: two synchronizer stages, then the register or latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_en | input | 1 | Load enable, active high, asynchronous |
| ser_out | output | 1 | Register bit 31, for chaining |
| ref_div | output | 14 | Held reference divide value |
| n_div | output | 10 | Held main divide value |
| a_div | output | 7 | Held swallow divide value |

## Verification
Every result is due on the third system clock edge after the pin change that causes it. This holds for a shift seen on the serial output and for a load seen on the divide outputs. The bench drives the pins on falling edges and holds each level for four clocks, so every check lands after that third edge. One test samples a load after exactly two edges and then three, to confirm that the value is still old and then new. The sweep covers a range of computed words with mixed control flags, all-ones and all-zeros words, and shift clock edges sent while enable is high.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int unsigned DEF_REF_W   = 14;
  localparam int unsigned DEF_MAIN_W  = 10;
  localparam int unsigned DEF_SWAL_W  = 7;
  localparam int unsigned DEF_SYNC_N  = 2;
  localparam int unsigned DEF_REF_RST  = 3;
  localparam int unsigned DEF_MAIN_RST = 16;
  localparam int unsigned DEF_SWAL_RST = 0;

  // Pin order inside the synchronized vector
  typedef enum int unsigned {
    PIN_SCLK = 0,
    PIN_DATA = 1,
    PIN_LOAD = 2
  } pin_idx_e;
  localparam int unsigned PIN_COUNT = 3;
endpackage

// File: rtl/prog_pin_sync.sv
module prog_pin_sync #(
  parameter int unsigned NUM    = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] pins_async,
  output logic [NUM-1:0] pins_sync
);
  for (genvar g = 0; g < NUM; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], pins_async[g]};
    end
    assign pins_sync[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/prog_shift_reg.sv
module prog_shift_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_lvl,
  input  logic         hold,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         last_bit
);
  logic prev_q;
  logic edge_seen;

  assign edge_seen = sclk_lvl & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      word   <= '0;
    end else begin
      prev_q <= sclk_lvl;
      if (edge_seen && !hold) word <= {word[W-2:0], din};
    end
  end

  assign last_bit = word[W-1];

  assert_lsb_takes_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_lvl && !prev_q && !hold) |=> word[0] == $past(din));
  assert_no_edge_no_move_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_lvl && !prev_q) |=> $stable(word));
  assert_ignore_while_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(word));
endmodule

// File: rtl/prog_latch_bank.sv
module prog_latch_bank #(
  parameter int unsigned REF_W    = 14,
  parameter int unsigned MAIN_W   = 10,
  parameter int unsigned SWAL_W   = 7,
  parameter int unsigned REF_RST  = 3,
  parameter int unsigned MAIN_RST = 16,
  parameter int unsigned SWAL_RST = 0,
  localparam int unsigned W = REF_W + MAIN_W + SWAL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [W-1:0]      word,
  output logic [REF_W-1:0]  ref_q,
  output logic [MAIN_W-1:0] main_q,
  output logic [SWAL_W-1:0] swal_q
);
  localparam int unsigned SW_LO = 1;
  localparam int unsigned SW_HI = SWAL_W;
  localparam int unsigned MN_LO = SWAL_W + 1;
  localparam int unsigned MN_HI = SWAL_W + MAIN_W;
  localparam int unsigned RF_LO = SWAL_W + MAIN_W + 1;
  localparam int unsigned RF_HI = W - 1;

  logic flag;
  assign flag = word[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= REF_W'(REF_RST);
      main_q <= MAIN_W'(MAIN_RST);
      swal_q <= SWAL_W'(SWAL_RST);
    end else if (load) begin
      main_q <= word[MN_HI:MN_LO];
      swal_q <= word[SW_HI:SW_LO];
      if (flag) ref_q <= word[RF_HI:RF_LO];
    end
  end

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(ref_q) && $stable(main_q) && $stable(swal_q)));
  assert_flag_low_keeps_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !word[0]) |=> $stable(ref_q));
  assert_flag_high_takes_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && word[0]) |=> ref_q == $past(word[RF_HI:RF_LO]));
  assert_main_swal_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (main_q == $past(word[MN_HI:MN_LO]) && swal_q == $past(word[SW_HI:SW_LO])));
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
  import synth_prog_pkg::*;
#(
  parameter int unsigned REF_W    = DEF_REF_W,
  parameter int unsigned MAIN_W   = DEF_MAIN_W,
  parameter int unsigned SWAL_W   = DEF_SWAL_W,
  parameter int unsigned SYNC_N   = DEF_SYNC_N,
  parameter int unsigned REF_RST  = DEF_REF_RST,
  parameter int unsigned MAIN_RST = DEF_MAIN_RST,
  parameter int unsigned SWAL_RST = DEF_SWAL_RST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_en,
  output logic              ser_out,
  output logic [REF_W-1:0]  ref_div,
  output logic [MAIN_W-1:0] n_div,
  output logic [SWAL_W-1:0] a_div
);
  localparam int unsigned WORD_W = REF_W + MAIN_W + SWAL_W + 1;

  logic [PIN_COUNT-1:0] pins_raw;
  logic [PIN_COUNT-1:0] pins_s;
  logic [WORD_W-1:0]    shift_word;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_SCLK] = ser_clk;
    pins_raw[PIN_DATA] = ser_dat;
    pins_raw[PIN_LOAD] = ser_en;
  end

  prog_pin_sync #(.NUM(PIN_COUNT), .STAGES(SYNC_N)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins_async (pins_raw),
    .pins_sync  (pins_s)
  );

  prog_shift_reg #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_lvl (pins_s[PIN_SCLK]),
    .hold     (pins_s[PIN_LOAD]),
    .din      (pins_s[PIN_DATA]),
    .word     (shift_word),
    .last_bit (ser_out)
  );

  prog_latch_bank #(
    .REF_W(REF_W), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W),
    .REF_RST(REF_RST), .MAIN_RST(MAIN_RST), .SWAL_RST(SWAL_RST)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (pins_s[PIN_LOAD]),
    .word   (shift_word),
    .ref_q  (ref_div),
    .main_q (n_div),
    .swal_q (a_div)
  );
endmodule

// File: tb/synth_prog_port_test.sv
module synth_prog_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
  logic ser_out;
  logic [13:0] ref_div;
  logic [9:0]  n_div;
  logic [6:0]  a_div;

  int total = 0;
  int bad = 0;
  logic [31:0] sr_m = '0;
  logic [13:0] ref_e = 14'd3;
  logic [9:0]  n_e = 10'd16;
  logic [6:0]  a_e = 7'd0;

  always #4 clk = ~clk;

  synth_prog_port uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_en(ser_en), .ser_out(ser_out), .ref_div(ref_div),
    .n_div(n_div), .a_div(a_div)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b; ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    sr_m = {sr_m[30:0], b};
    check("R1/R7 shift serial out", {31'd0, ser_out}, {31'd0, sr_m[31]});
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) send_bit(w[i]);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic model_load();
    n_e = sr_m[17:8];
    a_e = sr_m[7:1];
    if (sr_m[0]) ref_e = sr_m[31:18];
  endtask

  task automatic pulse_load();
    ser_en = 1'b1;
    repeat (4) @(negedge clk);
    ser_en = 1'b0;
    repeat (4) @(negedge clk);
    model_load();
  endtask

  task automatic check_outs(input string tag);
    check({tag, " ref"}, {18'd0, ref_div}, {18'd0, ref_e});
    check({tag, " main"}, {22'd0, n_div}, {22'd0, n_e});
    check({tag, " swal"}, {25'd0, a_div}, {25'd0, a_e});
  endtask

  function automatic logic [31:0] mk(input int r, input int n, input int a, input bit c);
    logic [13:0] rr = 14'(r);
    logic [9:0]  nn = 10'(n);
    logic [6:0]  aa = 7'(a);
    return {rr, nn, aa, c};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset values
    check_outs("R9 reset");
    check("R9 reset serial out", {31'd0, ser_out}, 32'd0);

    // R2 R3 R4 R5 sweep over computed words, mixed flags
    for (int k = 0; k < 20; k++) begin
      logic [31:0] w = mk(k * 2731 + 3, k * 389 + 16, k * 53 + 1, (k % 3) != 0);
      send_word(w);
      // R6: new bits shifted, latches not touched yet
      check_outs("R6 before load");
      check("R7 serial out before load", {31'd0, ser_out}, {31'd0, w[31]});
      pulse_load();
      check_outs(w[0] ? "R3 R5 flag=1 load" : "R4 R5 flag=0 load");
    end

    // boundaries: all ones with flag 1, all zeros with flag 0
    send_word(32'hFFFF_FFFF);
    pulse_load();
    check_outs("R2 R3 all ones");
    send_word(32'h0000_0000);
    pulse_load();
    check_outs("R4 all zeros keeps ref");
    check("R4 ref held", {18'd0, ref_div}, 32'h3FFF);

    // R8: shift edges during enable are ignored
    send_word(mk(1234, 567, 89, 1'b1));
    ser_en = 1'b1;
    repeat (4) @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      ser_dat = ~ser_dat;
      ser_clk = 1'b1; repeat (4) @(negedge clk);
      ser_clk = 1'b0; repeat (4) @(negedge clk);
    end
    ser_en = 1'b0;
    repeat (4) @(negedge clk);
    model_load();
    check("R8 serial out unchanged", {31'd0, ser_out}, {31'd0, sr_m[31]});
    check_outs("R8 load while edges");
    pulse_load();
    check_outs("R8 register untouched");
    check("R8 ref value", {18'd0, ref_div}, 32'd1234);

    // R10 latency: old after two edges, new after three
    send_word(mk(777, 333, 44, 1'b1));
    ser_en = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 ref still old at edge 2", {18'd0, ref_div}, 32'd1234);
    @(negedge clk);
    check("R10 ref new at edge 3", {18'd0, ref_div}, 32'd777);
    repeat (2) @(negedge clk);
    ser_en = 1'b0;
    repeat (4) @(negedge clk);
    model_load();
    check_outs("R10 after load");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule